// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block sequences one 12-bit successive-approximation conversion on one of four multiplexed analog channels. A start pulse taken while the block is idle captures the channel number and drives it onto a mux-select output. A fixed run of setup clocks follows, for mux settling, sampling and comparator zeroing. Then twelve bit decisions are made, most significant bit first, one per clock. For each decision the block drives a trial code to the converter's DAC and reads back a one-bit comparator result.

The readable result register follows one of two policies. In transparent mode each decision is written to the result as soon as it is made, so the upper four bits can be read partway through a conversion. In latched mode the result changes only when a conversion finishes, and it holds the previous value steady while the next conversion runs. A busy line, its inverse as a status flag, and two validity outputs report progress. Transparent mode is selected after reset, and the mode can be written only while the block is idle.

Top module: `sar_conv_seq`

## Requirements
- R1: After reset, busy is 1, statusFlag is 0, resultOut is 0, hiValid and fullValid are 0, muxSel is 0, and transparent mode is selected.
- R2: A startPulse sampled by a rising edge while busy is 1 drives busy to 0 at that edge (edge 0). Five setup clocks follow, then twelve decision clocks, and busy returns to 1 at edge 17.
- R3: statusFlag is always the inverse of busy.
- R4: chanSel is captured at the accepted start edge and held on muxSel, unchanged, until the next accepted start.
- R5: During decision clock k (edges 5 to 16), trialCode equals the bits already decided with the current trial bit set to 1, counting from bit 11 downward. The bit is kept when compIn is 1 (trial code at or below the input) and is cleared otherwise. With a monotonic comparator, the final result equals the input code.
- R6: In transparent mode the result is cleared at the start edge. Each decision is copied into resultOut at the edge that makes it (bit 11 at edge 6, bit 0 at edge 17), and bits not yet decided read 0. resultOut[11:8] are therefore complete after edge 9.
- R7: In latched mode resultOut changes only at edge 17 of a conversion. It holds the previous result unchanged through every edge of the next conversion.
- R8: In transparent mode hiValid and fullValid are cleared at the start edge, hiValid sets at edge 9 and fullValid sets at edge 17. In latched mode both set at edge 17 and are not cleared by a start.
- R9: A startPulse sampled while busy is 0 is ignored. It neither changes muxSel nor alters the timing of busy or the result.
- R10: modeWr with modeVal (1 = latched, 0 = transparent) takes effect only while busy is 1. A write while busy is 0 is ignored, and a mode write never changes resultOut.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | Conversion start request |
| chanSel | input | 2 | Channel number sampled at start |
| modeWr | input | 1 | Mode write strobe |
| modeVal | input | 1 | Mode to write: 1 latched, 0 transparent |
| compIn | input | 1 | Comparator: 1 when trialCode is at or below the input |
| trialCode | output | 12 | Trial code to the DAC |
| muxSel | output | 2 | Channel select held for the conversion |
| resultOut | output | 12 | Readable result register |
| busy | output | 1 | 0 while converting, 1 when idle |
| statusFlag | output | 1 | Inverse of busy |
| hiValid | output | 1 | Upper four result bits valid |
| fullValid | output | 1 | Full 12-bit result valid |

## Verification
The hardest situations to reach are requests that land inside a running conversion: a start pulse or a mode write arriving on an arbitrary clock between the accepted start and the final decision. The stimulus injects such requests on a randomly chosen clock of many conversions, and flips the channel input at the same time. Every clock of the conversion is then checked against a cycle-indexed model of busy, muxSel, trialCode and the result, so any disturbance shows up. A mode write made during a latched conversion is also checked on the following conversion, which must still hold its result.

// File: rtl/sar_conv_pkg.sv
package sar_conv_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_DECIDE = 2'd2
  } phase_t;

  // Strobes sent from control to datapath each cycle
  typedef struct packed {
    logic capture;  // start accepted this edge
    logic decide;   // a bit decision is made this edge
    logic hiDone;   // the decision this edge completes the upper bits
    logic finish;   // the decision this edge is the last one
    logic modeWr;   // accepted mode write
  } seqStrobe_t;

endpackage

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_conv_pkg::*;
#(
  parameter int unsigned DATA_W    = 12,
  parameter int unsigned SETUP_CYC = 5,
  parameter int unsigned HI_BITS   = 4,
  localparam int unsigned IDX_W    = $clog2(DATA_W),
  localparam int unsigned CNT_W    = $clog2(SETUP_CYC + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic             modeWrReq,
  output seqStrobe_t       st,
  output logic [IDX_W-1:0] stepIdx,
  output logic             busy
);

  localparam logic [IDX_W-1:0] TOP_IDX  = IDX_W'(DATA_W - 1);
  localparam logic [IDX_W-1:0] HI_IDX   = IDX_W'(DATA_W - HI_BITS);
  localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(SETUP_CYC - 1);

  phase_t           phase;
  logic [CNT_W-1:0] setupCnt;
  logic [IDX_W-1:0] bitIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      setupCnt <= '0;
      bitIdx   <= '0;
      busy     <= 1'b1;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (startPulse) begin
            phase    <= PH_SETUP;
            setupCnt <= '0;
            busy     <= 1'b0;
          end
        end
        PH_SETUP: begin
          if (setupCnt == SETUP_LAST) begin
            phase  <= PH_DECIDE;
            bitIdx <= TOP_IDX;
          end else begin
            setupCnt <= setupCnt + 1'b1;
          end
        end
        PH_DECIDE: begin
          if (bitIdx == '0) begin
            phase <= PH_IDLE;
            busy  <= 1'b1;
          end else begin
            bitIdx <= bitIdx - 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    st         = '0;
    st.capture = (phase == PH_IDLE) && startPulse;
    st.decide  = (phase == PH_DECIDE);
    st.hiDone  = st.decide && (bitIdx == HI_IDX);
    st.finish  = st.decide && (bitIdx == '0);
    st.modeWr  = (phase == PH_IDLE) && modeWrReq;
  end

  assign stepIdx = bitIdx;

  // R2: decisions begin only after the full setup run
  assert_setup_len_R2: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DECIDE && $past(phase) == PH_SETUP) |-> ($past(setupCnt) == SETUP_LAST));

  // R2: busy stays low while a conversion is in progress
  assert_busy_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_IDLE) |-> !busy);

  // R9: an unfinished decision run is not disturbed by a start request
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DECIDE && bitIdx != '0) |=> (phase == PH_DECIDE));

endmodule

// File: rtl/sar_conv_dp.sv
module sar_conv_dp
  import sar_conv_pkg::*;
#(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned CHAN_W = 2,
  localparam int unsigned IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        st,
  input  logic [IDX_W-1:0]  stepIdx,
  input  logic              compIn,
  input  logic [CHAN_W-1:0] chanSel,
  input  logic              modeVal,
  output logic [DATA_W-1:0] trialCode,
  output logic [DATA_W-1:0] resultOut,
  output logic [CHAN_W-1:0] muxSel,
  output logic              hiValid,
  output logic              fullValid
);

  logic [DATA_W-1:0] sarReg;
  logic [DATA_W-1:0] sarNext;
  logic [DATA_W-1:0] trialMask;
  logic              latchedMode;

  always_comb begin
    trialMask = '0;
    sarNext   = sarReg;
    for (int i = 0; i < DATA_W; i++) begin
      if (st.decide && (IDX_W'(i) == stepIdx)) begin
        trialMask[i] = 1'b1;
        sarNext[i]   = compIn;
      end
    end
  end

  assign trialCode = sarReg | trialMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sarReg      <= '0;
      resultOut   <= '0;
      muxSel      <= '0;
      hiValid     <= 1'b0;
      fullValid   <= 1'b0;
      latchedMode <= 1'b0;
    end else begin
      if (st.modeWr) latchedMode <= modeVal;
      if (st.capture) begin
        sarReg <= '0;
        muxSel <= chanSel;
        if (!latchedMode) begin
          resultOut <= '0;
          hiValid   <= 1'b0;
          fullValid <= 1'b0;
        end
      end
      if (st.decide) begin
        sarReg <= sarNext;
        if (!latchedMode) resultOut <= sarNext;
        if (st.hiDone && !latchedMode) hiValid <= 1'b1;
        if (st.finish) begin
          resultOut <= sarNext;
          hiValid   <= 1'b1;
          fullValid <= 1'b1;
        end
      end
    end
  end

  // R7: in latched mode the result moves only on the final decision
  assert_latched_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (latchedMode && !st.finish) |=> $stable(resultOut));

  // R8: a full result implies the upper bits are valid
  assert_full_has_hi_R8: assert property (@(posedge clk) disable iff (!rstN)
    fullValid |-> hiValid);

  // R4: channel select moves only on an accepted start
  assert_mux_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !st.capture |=> $stable(muxSel));

  // R5: at most one trial bit is raised per decision
  assert_one_trial_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(trialMask));

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_conv_pkg::*;
#(
  parameter int unsigned DATA_W    = 12,
  parameter int unsigned CHAN_W    = 2,
  parameter int unsigned SETUP_CYC = 5,
  parameter int unsigned HI_BITS   = 4,
  localparam int unsigned IDX_W    = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic [CHAN_W-1:0] chanSel,
  input  logic              modeWr,
  input  logic              modeVal,
  input  logic              compIn,
  output logic [DATA_W-1:0] trialCode,
  output logic [CHAN_W-1:0] muxSel,
  output logic [DATA_W-1:0] resultOut,
  output logic              busy,
  output logic              statusFlag,
  output logic              hiValid,
  output logic              fullValid
);

  seqStrobe_t       st;
  logic [IDX_W-1:0] stepIdx;

  sar_conv_ctrl #(
    .DATA_W   (DATA_W),
    .SETUP_CYC(SETUP_CYC),
    .HI_BITS  (HI_BITS)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startPulse(startPulse),
    .modeWrReq (modeWr),
    .st        (st),
    .stepIdx   (stepIdx),
    .busy      (busy)
  );

  sar_conv_dp #(
    .DATA_W(DATA_W),
    .CHAN_W(CHAN_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .stepIdx  (stepIdx),
    .compIn   (compIn),
    .chanSel  (chanSel),
    .modeVal  (modeVal),
    .trialCode(trialCode),
    .resultOut(resultOut),
    .muxSel   (muxSel),
    .hiValid  (hiValid),
    .fullValid(fullValid)
  );

  assign statusFlag = ~busy;

  // R8: completion of a conversion always leaves a full result
  assert_done_full_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> fullValid);

endmodule

// File: tb/sar_conv_seq_bench.sv
`timescale 1ns/1ps
module sar_conv_seq_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic [1:0]  chanSel = '0;
  logic        modeWr = 1'b0;
  logic        modeVal = 1'b0;
  logic        compIn;
  logic [11:0] trialCode;
  logic [1:0]  muxSel;
  logic [11:0] resultOut;
  logic        busy, statusFlag, hiValid, fullValid;

  logic [11:0] analogVal = '0;
  int checks = 0;
  int fails = 0;

  // bench model state
  logic [11:0] expOut = '0;
  logic        expLatched = 1'b0;
  logic        expPrevValid = 1'b0;

  always #2.5 clk = ~clk;

  // monotonic comparator model
  assign compIn = (trialCode <= analogVal);

  sar_conv_seq u_sar_conv_seq (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .chanSel(chanSel),
    .modeWr(modeWr), .modeVal(modeVal), .compIn(compIn),
    .trialCode(trialCode), .muxSel(muxSel), .resultOut(resultOut),
    .busy(busy), .statusFlag(statusFlag), .hiValid(hiValid), .fullValid(fullValid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] topMask(input int n);
    logic [11:0] m = '0;
    for (int i = 0; i < n && i < 12; i++) m[11-i] = 1'b1;
    return m;
  endfunction

  // Check every port at edge e of a conversion (edge 0 = accepted start)
  task automatic checkEdge(input int e, input logic [1:0] chan, input logic [11:0] val);
    int decided;
    logic [11:0] eOut;
    logic eHi, eFull;
    decided = (e < 6) ? 0 : ((e - 5 > 12) ? 12 : e - 5);
    if (!expLatched) begin
      eOut  = val & topMask(decided);
      eHi   = (decided >= 4);
      eFull = (e == 17);
    end else begin
      eOut  = (e == 17) ? val : expOut;
      eHi   = (e == 17) ? 1'b1 : expPrevValid;
      eFull = eHi;
    end
    check("R2 busy", 32'(busy), 32'(e == 17));
    check("R3 statusFlag", 32'(statusFlag), 32'(!busy));
    check("R4/R9 muxSel", 32'(muxSel), 32'(chan));
    check(expLatched ? "R7 result" : "R6 result", 32'(resultOut), 32'(eOut));
    check("R8 hiValid", 32'(hiValid), 32'(eHi));
    check("R8 fullValid", 32'(fullValid), 32'(eFull));
    if (e >= 5 && e <= 16)
      check("R5 trialCode", 32'(trialCode),
            32'((val & topMask(e - 5)) | (12'h800 >> (e - 5))));
  endtask

  task automatic runConv(input logic [1:0] chan, input logic [11:0] val,
                         input int injStart, input int injMode);
    analogVal = val;
    @(negedge clk);
    startPulse = 1'b1;
    chanSel = chan;
    @(negedge clk);
    startPulse = 1'b0;
    checkEdge(0, chan, val);
    for (int e = 1; e <= 17; e++) begin
      @(negedge clk);
      checkEdge(e, chan, val);
      startPulse = (e == injStart);
      chanSel    = (e == injStart) ? ~chan : chan;
      modeWr     = (e == injMode);
      modeVal    = ~expLatched;
    end
    startPulse = 1'b0;
    modeWr = 1'b0;
    check("R5 final result", 32'(resultOut), 32'(val));
    expOut = val;
    expPrevValid = 1'b1;
  endtask

  task automatic writeMode(input logic v);
    @(negedge clk);
    modeWr = 1'b1;
    modeVal = v;
    @(negedge clk);
    modeWr = 1'b0;
    expLatched = v;
    check("R10 result unchanged by mode write", 32'(resultOut), 32'(expOut));
    check("R10 busy stays idle", 32'(busy), 32'd1);
  endtask

  initial begin
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk);
    check("R1 busy", 32'(busy), 32'd1);
    check("R1 statusFlag", 32'(statusFlag), 32'd0);
    check("R1 result", 32'(resultOut), 32'd0);
    check("R1 hiValid", 32'(hiValid), 32'd0);
    check("R1 fullValid", 32'(fullValid), 32'd0);
    check("R1 muxSel", 32'(muxSel), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle after release", 32'(busy), 32'd1);

    // transparent mode (R1 default), directed corners
    runConv(2'd0, 12'h000, 0, 0);
    runConv(2'd3, 12'hFFF, 0, 0);
    runConv(2'd1, 12'h800, 0, 0);
    runConv(2'd2, 12'h7FF, 0, 0);
    for (int k = 0; k < 8; k++)
      runConv(2'($urandom), 12'($urandom), 1 + int'($urandom % 16), 0);

    // switch to latched mode while idle
    writeMode(1'b1);
    runConv(2'd2, 12'hA5A, 0, 0);
    runConv(2'd1, 12'h000, 3, 0);
    for (int k = 0; k < 8; k++)
      runConv(2'($urandom), 12'($urandom), 1 + int'($urandom % 16),
              (k % 2 == 0) ? 1 + int'($urandom % 16) : 0);
    // R10: mode writes made during the runs above were ignored, still latched
    runConv(2'd3, 12'h3C3, 0, 0);

    // back to transparent
    writeMode(1'b0);
    for (int k = 0; k < 4; k++)
      runConv(2'($urandom), 12'($urandom), 1 + int'($urandom % 16), 2 + int'($urandom % 10));
    runConv(2'd0, 12'h001, 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule